// File: doc/BRIEF.md
# Microsequenced SUBLEQ Processor Core

This block is a processor with a single instruction: subtract and branch if the result is less than or equal to zero. An instruction occupies three consecutive words holding addresses A, B and C. The core reads the operand at A and the operand at B, then stores B minus A back at B. It then jumps to C when that result is zero or negative. Otherwise it continues with the instruction three words further on. Data words and addresses share one width, set by a single parameter: 4 bits by default, 8 bits as the wider build.

The core contains a small register-file RAM, a program counter, a transfer register that carries every fetched address, two operand registers, and a subtractor. The subtractor is an adder whose second input is inverted and whose carry-in is forced high. A zero-or-negative detector decides the branch. A 3-bit step counter orders the micro-operations: a taken branch uses six steps, and a fall-through ends after four.

The all-ones address is not memory. Reading it returns the input port, and writing it loads the output register. A branch to the all-ones address halts the core. While the core is halted, a load port can fill and read back the RAM, and a start pulse begins execution at address 0.

Top module: `sq_core`

## Requirements
- R1: After reset the core is halted (`halted` = 1) and `out_data` is 0.
- R2: While halted, a cycle with `ld_we` = 1 writes `ld_data` into RAM word `ld_addr`, including the all-ones word. `ld_rdata` always shows RAM word `ld_addr` combinationally.
- R3: Each instruction stores (mem[B] - mem[A]) mod 2^W into word B.
- R4: The branch is taken when the stored result has its top bit set or is all zeros. A taken branch loads the program counter with C.
- R5: A fall-through instruction advances the program counter by 3 and takes 4 clock cycles. A taken branch takes 6 clock cycles. A start pulse accepted at one edge is followed by the first step at the next edge.
- R6: An operand read from the all-ones address returns `in_data` instead of RAM.
- R7: A result written to the all-ones address loads `out_data` and leaves every RAM word unchanged.
- R8: A taken branch whose target C is the all-ones address sets `halted` at the edge that loads the program counter. While halted, the program counter and `out_data` hold.
- R9: While running, `ld_we` has no effect on RAM.
- R10: `go` while halted restarts execution at address 0. `go` while running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| go | input | 1 | Start pulse, accepted only while halted |
| ld_we | input | 1 | Load-port write enable, effective only while halted |
| ld_addr | input | W | Load-port word address (write and readback) |
| ld_data | input | W | Load-port write data |
| ld_rdata | output | W | RAM word at `ld_addr`, combinational |
| in_data | input | W | Value returned by reads of the all-ones address |
| out_data | output | W | Output register, loaded by writes to the all-ones address |
| halted | output | 1 | High while execution is stopped |

## Verification
Timing is checked by counting clock cycles rather than by observing internal state. A start pulse is registered at one edge. A program of N fall-through instructions, m non-halting taken branches and a final halting branch therefore raises `halted` exactly 4N + 6m + 6 edges after that edge. The bench samples on falling edges and compares the count with that figure. `out_data` and the RAM words are read only after `halted` rises, and RAM is read back through the combinational load-port readback, so every result has settled before it is compared. Each check also covers the ignored cases: a start pulse or a load issued mid-run must leave both the cycle count and the RAM untouched.

// File: rtl/sq_pkg.sv
package sq_pkg;
  // Micro-step encoding; the 3-bit counter never reaches 6 or 7.
  typedef enum logic [2:0] {
    ST_FETCH_A = 3'd0,
    ST_LOAD_A  = 3'd1,
    ST_LOAD_B  = 3'd2,
    ST_EXEC    = 3'd3,
    ST_FETCH_C = 3'd4,
    ST_JUMP    = 3'd5
  } step_e;

  localparam int STEP_W    = 3;
  localparam int RD_PORTS  = 3;  // fetch, operand, load readback
  localparam int RD_FETCH  = 0;
  localparam int RD_OPND   = 1;
  localparam int RD_LOAD   = 2;
endpackage

// File: rtl/sq_ram.sv
module sq_ram #(
  parameter int W      = 4,
  parameter int NREAD  = 3
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [W-1:0]            waddr,
  input  logic [W-1:0]            wdata,
  input  logic [NREAD-1:0][W-1:0] raddr,
  output logic [NREAD-1:0][W-1:0] rdata
);
  localparam int DEPTH = 1 << W;

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  for (genvar g = 0; g < NREAD; g++) begin : g_rd
    assign rdata[g] = mem[raddr[g]];
  end
endmodule

// File: rtl/sq_alu.sv
module sq_alu #(
  parameter int W = 4
) (
  input  logic [W-1:0] a_op,   // subtrahend, mem[A]
  input  logic [W-1:0] b_op,   // minuend, mem[B]
  output logic [W-1:0] diff,
  output logic         leq
);
  // Adder with inverted second input and carry-in forced to one.
  function automatic logic [W:0] add_inverted(input logic [W-1:0] x,
                                              input logic [W-1:0] y);
    logic [W:0] s;
    s = {1'b0, x} + {1'b0, ~y} + {{W{1'b0}}, 1'b1};
    return s;
  endfunction

  function automatic logic zero_or_neg(input logic [W-1:0] v);
    return v[W-1] | (v == '0);
  endfunction

  logic [W:0] sum_full;
  assign sum_full = add_inverted(b_op, a_op);
  assign diff     = sum_full[W-1:0];
  assign leq      = zero_or_neg(diff);

  // R3: adding the subtrahend back must recover the minuend.
  always_comb begin
    a_r3_sub_inverse: assert (W'(diff + a_op) == b_op);
  end
endmodule

// File: rtl/sq_step.sv
module sq_step
  import sq_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,      // restart at the first step
  input  logic  run,
  input  logic  early_end,  // fall-through: wrap after the execute step
  output step_e step
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         step <= ST_FETCH_A;
    else if (start)                     step <= ST_FETCH_A;
    else if (run) begin
      if (early_end || step == ST_JUMP) step <= ST_FETCH_A;
      else                              step <= step_e'(step + 3'd1);
    end
  end

  // R5: the counter stays within the six defined steps.
  a_r5_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
    step <= ST_JUMP);
  // R5: an early end always returns to the first step.
  a_r5_early_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !start && early_end) |=> step == ST_FETCH_A);
endmodule

// File: rtl/sq_core.sv
module sq_core
  import sq_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic         ld_we,
  input  logic [W-1:0] ld_addr,
  input  logic [W-1:0] ld_data,
  output logic [W-1:0] ld_rdata,
  input  logic [W-1:0] in_data,
  output logic [W-1:0] out_data,
  output logic         halted
);
  localparam logic [W-1:0] IO_ADDR = '1;
  localparam logic [W-1:0] STRIDE  = W'(3);

  logic [W-1:0] pc_q, xfr_q, a_q, b_q, out_q;
  logic         halted_q;
  step_e        step;

  // Named internal events
  logic run, start, io_sel, core_wr, load_wr, early_end, alu_leq;
  logic [W-1:0] alu_diff, fetch_off, operand;
  logic                      ram_we;
  logic [W-1:0]              ram_waddr, ram_wdata;
  logic [RD_PORTS-1:0][W-1:0] ram_raddr, ram_rdata;

  assign run       = !halted_q;
  assign start     = halted_q && go;
  assign io_sel    = (xfr_q == IO_ADDR);
  assign core_wr   = run && (step == ST_EXEC);
  assign early_end = core_wr && !alu_leq;
  assign load_wr   = halted_q && ld_we;

  always_comb begin
    unique case (step)
      ST_LOAD_A:  fetch_off = W'(1);
      ST_FETCH_C: fetch_off = W'(2);
      default:    fetch_off = '0;
    endcase
  end

  assign ram_raddr[RD_FETCH] = pc_q + fetch_off;
  assign ram_raddr[RD_OPND]  = xfr_q;
  assign ram_raddr[RD_LOAD]  = ld_addr;
  assign operand  = io_sel ? in_data : ram_rdata[RD_OPND];
  assign ld_rdata = ram_rdata[RD_LOAD];

  assign ram_we    = load_wr || (core_wr && !io_sel);
  assign ram_waddr = load_wr ? ld_addr : xfr_q;
  assign ram_wdata = load_wr ? ld_data : alu_diff;

  sq_ram #(.W(W), .NREAD(RD_PORTS)) u_ram (
    .clk   (clk),
    .we    (ram_we),
    .waddr (ram_waddr),
    .wdata (ram_wdata),
    .raddr (ram_raddr),
    .rdata (ram_rdata)
  );

  sq_alu #(.W(W)) u_alu (
    .a_op (a_q),
    .b_op (b_q),
    .diff (alu_diff),
    .leq  (alu_leq)
  );

  sq_step u_step (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .run       (run),
    .early_end (early_end),
    .step      (step)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q     <= '0;
      xfr_q    <= '0;
      a_q      <= '0;
      b_q      <= '0;
      out_q    <= '0;
      halted_q <= 1'b1;
    end else if (start) begin
      pc_q     <= '0;
      halted_q <= 1'b0;
    end else if (run) begin
      unique case (step)
        ST_FETCH_A: xfr_q <= ram_rdata[RD_FETCH];
        ST_LOAD_A: begin
          a_q   <= operand;
          xfr_q <= ram_rdata[RD_FETCH];
        end
        ST_LOAD_B:  b_q <= operand;
        ST_EXEC: begin
          if (io_sel)   out_q <= alu_diff;
          if (!alu_leq) pc_q  <= pc_q + STRIDE;
        end
        ST_FETCH_C: xfr_q <= ram_rdata[RD_FETCH];
        ST_JUMP: begin
          pc_q <= xfr_q;
          if (io_sel) halted_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign out_data = out_q;
  assign halted   = halted_q;

  // R5: fall-through advances by the stride and restarts the sequence.
  a_r5_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
    early_end |=> (step == ST_FETCH_A) && ((pc_q - $past(pc_q)) == STRIDE));
  // R4: a taken branch lands on the fetched target.
  a_r4_branch_target: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step == ST_JUMP) |=> pc_q == $past(xfr_q));
  // R7: an I/O write updates the output register with the difference.
  a_r7_io_write: assert property (@(posedge clk) disable iff (!rst_n)
    (core_wr && io_sel) |=> out_q == $past(alu_diff));
  // R8: branch to the I/O address halts.
  a_r8_halt_on_io: assert property (@(posedge clk) disable iff (!rst_n)
    (run && step == ST_JUMP && io_sel) |=> halted_q);
  // R8: nothing moves while halted.
  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_q && !go) |=> ($stable(pc_q) && $stable(out_q)));
  // R9: load port cannot write during execution.
  a_r9_load_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !core_wr) |-> !ram_we);
  // R10: a start pulse always resumes from address zero.
  a_r10_start_zero: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (pc_q == '0) && !halted_q && (step == ST_FETCH_A));
endmodule

// File: tb/test_sq_core.sv
module test_sq_core;
  localparam int CLK_PERIOD = 10;
  localparam int W = 4;
  localparam int DEPTH = 1 << W;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         go = 1'b0;
  logic         ld_we = 1'b0;
  logic [W-1:0] ld_addr = '0;
  logic [W-1:0] ld_data = '0;
  logic [W-1:0] ld_rdata;
  logic [W-1:0] in_data = '0;
  logic [W-1:0] out_data;
  logic         halted;

  int checks = 0;
  int errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sq_core #(.W(W)) i_sq_core (
    .clk(clk), .rst_n(rst_n), .go(go), .ld_we(ld_we), .ld_addr(ld_addr),
    .ld_data(ld_data), .ld_rdata(ld_rdata), .in_data(in_data),
    .out_data(out_data), .halted(halted)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic load(input int a, input int d);
    @(negedge clk);
    ld_addr = W'(a); ld_data = W'(d); ld_we = 1'b1;
    @(negedge clk);
    ld_we = 1'b0;
  endtask

  task automatic clear_ram();
    for (int i = 0; i < DEPTH; i++) load(i, 0);
  endtask

  function automatic int peek_now();
    return int'(ld_rdata);
  endfunction

  task automatic peek(input string tag, input int a, input int exp);
    @(negedge clk);
    ld_addr = W'(a);
    #1;
    check(tag, peek_now(), exp);
  endtask

  // Pulse go, count edges until halted; n = cycles after the start edge.
  task automatic run_count(output int n);
    @(negedge clk);
    go = 1'b1;
    @(negedge clk);
    go = 1'b0;
    n = 0;
    while (!halted && n < 500) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic t_reset();
    check("R1 halted after reset", int'(halted), 1);
    check("R1 out_data after reset", int'(out_data), 0);
  endtask

  task automatic t_load();
    clear_ram();
    load(5, 11);
    load(15, 6);
    peek("R2 readback word 5", 5, 11);
    peek("R2 readback all-ones word", 15, 6);
  endtask

  // 5-3=2 falls through, then 0 branches to 15.
  task automatic t_fallthrough();
    int n;
    clear_ram();
    load(0, 12); load(1, 13); load(2, 0);
    load(3, 14); load(4, 14); load(5, 15);
    load(12, 3); load(13, 5); load(14, 7);
    run_count(n);
    check("R5 cycles fall-through+halt", n, 10);
    check("R8 halted after branch to all-ones", int'(halted), 1);
    peek("R3 mem[B]=5-3", 13, 2);
    peek("R4 zero result stored", 14, 0);
  endtask

  // 3-5 = -2 (14) is negative: jump to 6 which halts.
  task automatic t_negative();
    int n;
    clear_ram();
    load(0, 12); load(1, 13); load(2, 6);
    load(6, 14); load(7, 14); load(8, 15);
    load(12, 5); load(13, 3); load(14, 1);
    run_count(n);
    check("R4 negative branch cycles", n, 12);
    peek("R3 wrapped difference", 13, 14);
  endtask

  // Reads from 15 return in_data, write to 15 sets out_data only.
  task automatic t_io();
    int n;
    clear_ram();
    load(0, 15); load(1, 13); load(2, 0);
    load(3, 12); load(4, 15); load(5, 0);
    load(6, 14); load(7, 14); load(8, 15);
    load(12, 0); load(13, 7); load(15, 9);
    in_data = W'(2);
    run_count(n);
    check("R5 cycles io program", n, 14);
    peek("R6 mem[13]=7-in", 13, 5);
    check("R7 out_data=in-0", int'(out_data), 2);
    peek("R7 RAM word 15 untouched", 15, 9);
    in_data = '0;
  endtask

  // go and ld_we pulsed mid-run must be ignored.
  task automatic t_ignore_while_running();
    int n;
    clear_ram();
    load(0, 12); load(1, 13); load(2, 0);
    load(3, 14); load(4, 14); load(5, 15);
    load(12, 3); load(13, 5); load(14, 7);
    @(negedge clk); go = 1'b1;
    @(negedge clk); go = 1'b0;
    @(negedge clk);
    go = 1'b1; ld_we = 1'b1; ld_addr = W'(13); ld_data = W'(9);
    @(negedge clk);
    go = 1'b0; ld_we = 1'b0;
    n = 2;
    while (!halted && n < 500) begin
      @(negedge clk);
      n++;
    end
    check("R10 go while running ignored (cycles)", n, 10);
    peek("R9 load while running ignored", 13, 2);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_load();
    t_fallthrough();
    t_negative();
    t_io();
    t_ignore_while_running();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule